// File: doc/BRIEF.md
# Receive Word Match Filter

This block sits on the receive path of a serial peripheral, between the shift register that assembles incoming words and the FIFO that holds them. For every completed word it decides whether the word goes into the FIFO. It also compares the word against programmed criteria and raises a sticky hit flag when a comparison succeeds.

Three comparison settings exist: off, equal to either of two reference words, or equal to the first reference word in the bit positions where the second reference word has ones. The comparison can be limited to the first one or the first two stored words after a start-of-frame pulse. A hunt setting drops all data until the first hit. Words flagged by the receive-mask input are always dropped. They are also invisible to the comparison and to the frame window.

Top module: `rx_match_filter`

## Requirements
- R1: After reset, `store_vld` and `hit_flag` are both 0.
- R2: A word presented with `rx_mask`=1 is never stored: `store_vld` stays 0 in the following cycle.
- R3: With `cmp_mode`=1 (either-word), an unmasked eligible word equal to `ref_a` or to `ref_b` sets `hit_flag` one cycle later. Other words leave it unchanged.
- R4: With `cmp_mode`=2 (masked), an unmasked eligible word sets `hit_flag` when it equals `ref_a` in every bit position where `ref_b` is 1. Bits where `ref_b` is 0 are ignored.
- R5: With `win_mode`=1, only the first unmasked word since the last `sof` pulse is compared.
- R6: With `win_mode`=2, only the first two unmasked words since the last `sof` pulse are compared. With `win_mode` 0 or 3, every word is compared.
- R7: Masked words cannot set `hit_flag` and do not advance the frame window. A match on the first word therefore waits until the masked words have passed.
- R8: `hit_flag` is sticky. Only a `hit_clr` pulse clears it, and a hit in the same cycle as `hit_clr` wins.
- R9: With `hunt`=1 and `hit_flag`=0, non-matching words are dropped. The matching word itself is stored, and later words are stored while `hit_flag` stays 1.
- R10: If `hit_flag` is cleared while `hunt` is still 1, dropping resumes. Clearing `hunt` first and `hit_flag` second restores normal storage.
- R11: An unmasked word that is kept appears on `store_vld`/`store_data` exactly one cycle after `word_vld`, with its data unchanged.
- R12: With `cmp_mode` 0 or 3, `hit_flag` is never set.
- R13: A `sof` pulse restarts the window. A word in the same cycle as `sof` counts as the first word of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Received word strobe |
| word_data | input | DATA_W | Received word |
| rx_mask | input | 1 | Discard this word |
| sof | input | 1 | Start-of-frame pulse |
| cmp_mode | input | 2 | 0 off, 1 either-word, 2 masked, 3 off |
| win_mode | input | 2 | 0 all words, 1 first word, 2 first two, 3 all |
| hunt | input | 1 | Drop data until a hit |
| ref_a | input | DATA_W | First reference word |
| ref_b | input | DATA_W | Second reference word or compare mask |
| hit_clr | input | 1 | Write-1-to-clear pulse for the flag |
| store_vld | output | 1 | Write strobe to the receive FIFO |
| store_data | output | DATA_W | Word to write |
| hit_flag | output | 1 | Sticky match flag |

## Verification
The either-word setting is driven with a word equal to neither reference, then with each reference in turn. This separates a comparison that checks only one reference from one that checks both. The masked setting uses a word that differs from `ref_a` only in unmasked bits, and another that differs in a masked bit, which shows whether the mask is applied. The window tests place the matching word at positions one, two and three after `sof`, with and without masked words ahead of it, to expose off-by-one counting and counting of dropped words. Hunt sequences clear the two controls in both orders, to show that the flag, and not the data, reopens the gate.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    typedef enum logic [1:0] {
        CMP_OFF    = 2'd0,
        CMP_EITHER = 2'd1,
        CMP_MASKED = 2'd2,
        CMP_RSVD   = 2'd3
    } cmp_mode_e;

    typedef enum logic [1:0] {
        WIN_ALL    = 2'd0,
        WIN_FIRST1 = 2'd1,
        WIN_FIRST2 = 2'd2,
        WIN_ALL2   = 2'd3
    } win_mode_e;

    localparam int unsigned WIN_MAX = 2;
    localparam int unsigned WIN_CW  = $clog2(WIN_MAX + 1);

    // number of leading words compared; 0 means no limit
    function automatic logic [WIN_CW-1:0] win_limit(input win_mode_e m);
        case (m)
            WIN_FIRST1: return WIN_CW'(1);
            WIN_FIRST2: return WIN_CW'(2);
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/rxm_window.sv
module rxm_window
    import rxm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sof,
    input  logic      take,
    input  win_mode_e win_mode,
    output logic      in_window
);
    logic [WIN_CW-1:0] cnt_q;
    logic [WIN_CW-1:0] cnt_now;
    logic [WIN_CW-1:0] lim;

    always_comb begin
        cnt_now   = sof ? '0 : cnt_q;
        lim       = win_limit(win_mode);
        in_window = (lim == '0) || (cnt_now < lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= (cnt_now >= WIN_CW'(WIN_MAX)) ? WIN_CW'(WIN_MAX) : cnt_now + 1'b1;
        end else if (sof) begin
            cnt_q <= '0;
        end
    end

    // R5: the counter saturates at the deepest window
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= WIN_CW'(WIN_MAX));

    // R13: a frame start without a word leaves the window at zero
    p_sof_restart_r13: assert property (@(posedge clk) disable iff (rst)
        (sof && !take) |=> (cnt_q == '0));
endmodule

// File: rtl/rxm_compare.sv
module rxm_compare
    import rxm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  cmp_mode_e          mode,
    input  logic [DATA_W-1:0]  data,
    input  logic [DATA_W-1:0]  ref_a,
    input  logic [DATA_W-1:0]  ref_b,
    output logic               hit
);
    logic eq_a;
    logic eq_b;
    logic eq_msk;

    always_comb begin
        eq_a   = (data == ref_a);
        eq_b   = (data == ref_b);
        eq_msk = (((data ^ ref_a) & ref_b) == '0);
        case (mode)
            CMP_EITHER: hit = eq_a || eq_b;
            CMP_MASKED: hit = eq_msk;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxm_gate.sv
module rxm_gate #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic              rx_mask,
    input  logic [DATA_W-1:0] word_data,
    input  logic              hit_q,
    input  logic              hunt,
    input  logic              hit_clr,
    output logic              store_vld,
    output logic [DATA_W-1:0] store_data,
    output logic              hit_flag
);
    logic keep;

    always_comb begin
        keep = word_vld && !rx_mask && (!hunt || hit_flag || hit_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_vld  <= 1'b0;
            store_data <= '0;
            hit_flag   <= 1'b0;
        end else begin
            store_vld <= keep;
            if (keep) begin
                store_data <= word_data;
            end
            hit_flag <= hit_q || (hit_flag && !hit_clr);
        end
    end

    // R2: masked words never reach the FIFO
    p_mask_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (word_vld && rx_mask) |=> !store_vld);

    // R8: the flag holds without a clear
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (hit_flag && !hit_clr) |=> hit_flag);

    // R11: a pass-through word arrives one cycle later, unchanged
    p_store_latency_r11: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !rx_mask && !hunt) |=> (store_vld && store_data == $past(word_data)));

    // R9: while hunting with no hit, nothing is stored
    p_hunt_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (hunt && !hit_flag && !hit_q) |=> !store_vld);
endmodule

// File: rtl/rx_match_filter.sv
module rx_match_filter
    import rxm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word_data,
    input  logic              rx_mask,
    input  logic              sof,
    input  logic [1:0]        cmp_mode,
    input  logic [1:0]        win_mode,
    input  logic              hunt,
    input  logic [DATA_W-1:0] ref_a,
    input  logic [DATA_W-1:0] ref_b,
    input  logic              hit_clr,
    output logic              store_vld,
    output logic [DATA_W-1:0] store_data,
    output logic              hit_flag
);
    cmp_mode_e cmode;
    win_mode_e wmode;
    logic      take;
    logic      in_window;
    logic      raw_hit;
    logic      hit_q;

    always_comb begin
        cmode = cmp_mode_e'(cmp_mode);
        wmode = win_mode_e'(win_mode);
        take  = word_vld && !rx_mask;
        hit_q = take && in_window && raw_hit;
    end

    rxm_window u_window (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .take      (take),
        .win_mode  (wmode),
        .in_window (in_window)
    );

    rxm_compare #(.DATA_W(DATA_W)) u_compare (
        .mode  (cmode),
        .data  (word_data),
        .ref_a (ref_a),
        .ref_b (ref_b),
        .hit   (raw_hit)
    );

    rxm_gate #(.DATA_W(DATA_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .word_vld   (word_vld),
        .rx_mask    (rx_mask),
        .word_data  (word_data),
        .hit_q      (hit_q),
        .hunt       (hunt),
        .hit_clr    (hit_clr),
        .store_vld  (store_vld),
        .store_data (store_data),
        .hit_flag   (hit_flag)
    );

    // R12: with comparison off, a clear flag stays clear
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!hit_flag && (cmp_mode == 2'd0 || cmp_mode == 2'd3)) |=> !hit_flag);

    // R7: a masked word alone cannot raise the flag
    p_mask_no_hit_r7: assert property (@(posedge clk) disable iff (rst)
        (!hit_flag && word_vld && rx_mask) |=> !hit_flag);
endmodule

// File: tb/sim_rx_match_filter.sv
module sim_rx_match_filter;
    localparam int W = 32;
    localparam logic [W-1:0] RA = 32'h1234_5678;
    localparam logic [W-1:0] RB = 32'hCAFE_0000;
    localparam logic [W-1:0] JUNK = 32'h0000_1111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_vld = 1'b0;
    logic [W-1:0] word_data = '0;
    logic rx_mask = 1'b0;
    logic sof = 1'b0;
    logic [1:0] cmp_mode = 2'd0;
    logic [1:0] win_mode = 2'd0;
    logic hunt = 1'b0;
    logic [W-1:0] ref_a = RA;
    logic [W-1:0] ref_b = RB;
    logic hit_clr = 1'b0;
    logic store_vld;
    logic [W-1:0] store_data;
    logic hit_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_match_filter #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word_data(word_data),
        .rx_mask(rx_mask), .sof(sof), .cmp_mode(cmp_mode), .win_mode(win_mode),
        .hunt(hunt), .ref_a(ref_a), .ref_b(ref_b), .hit_clr(hit_clr),
        .store_vld(store_vld), .store_data(store_data), .hit_flag(hit_flag)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one word; outputs are checked at the next falling edge
    task automatic send(input logic [W-1:0] d, input logic m, input logic s);
        @(negedge clk);
        word_vld = 1'b1; word_data = d; rx_mask = m; sof = s;
        @(negedge clk);
        word_vld = 1'b0; rx_mask = 1'b0; sof = 1'b0;
    endtask

    task automatic pulse_sof();
        @(negedge clk);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        hit_clr = 1'b1;
        @(negedge clk);
        hit_clr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 store_vld", W'(store_vld), '0);
        chk("R1 hit_flag", W'(hit_flag), '0);
    endtask

    task automatic t_either();
        cmp_mode = 2'd1; win_mode = 2'd0;
        send(JUNK, 1'b0, 1'b0);
        chk("R11 store_vld", W'(store_vld), 1);
        chk("R11 store_data", store_data, JUNK);
        chk("R3 no hit on junk", W'(hit_flag), 0);
        send(RA, 1'b0, 1'b0);
        chk("R3 hit on ref_a", W'(hit_flag), 1);
        send(JUNK, 1'b0, 1'b0);
        chk("R8 sticky", W'(hit_flag), 1);
        clear_flag();
        chk("R8 cleared", W'(hit_flag), 0);
        send(RB, 1'b0, 1'b0);
        chk("R3 hit on ref_b", W'(hit_flag), 1);
        clear_flag();
        @(negedge clk);
        word_vld = 1'b1; word_data = RA; hit_clr = 1'b1;
        @(negedge clk);
        word_vld = 1'b0; hit_clr = 1'b0;
        chk("R8 set wins over clear", W'(hit_flag), 1);
        clear_flag();
    endtask

    task automatic t_mask();
        send(RA, 1'b1, 1'b0);
        chk("R2 masked not stored", W'(store_vld), 0);
        chk("R7 masked no hit", W'(hit_flag), 0);
    endtask

    task automatic t_masked_mode();
        cmp_mode = 2'd2; ref_a = 32'h0000_00A5; ref_b = 32'h0000_00FF;
        send(32'hFFFF_FFA4, 1'b0, 1'b0);
        chk("R4 masked-bit differs", W'(hit_flag), 0);
        send(32'hFFFF_FFA5, 1'b0, 1'b0);
        chk("R4 unmasked bits ignored", W'(hit_flag), 1);
        clear_flag();
        ref_a = RA; ref_b = RB;
    endtask

    task automatic t_first1();
        cmp_mode = 2'd1; win_mode = 2'd1;
        send(JUNK, 1'b0, 1'b1);
        send(RA, 1'b0, 1'b0);
        chk("R5 second word ignored", W'(hit_flag), 0);
        send(RA, 1'b0, 1'b1);
        chk("R13 word with sof is first", W'(hit_flag), 1);
        clear_flag();
        pulse_sof();
        send(JUNK, 1'b1, 1'b0);
        send(JUNK, 1'b1, 1'b0);
        send(RA, 1'b0, 1'b0);
        chk("R7 masked words not counted", W'(hit_flag), 1);
        clear_flag();
    endtask

    task automatic t_first2();
        win_mode = 2'd2;
        pulse_sof();
        send(JUNK, 1'b0, 1'b0);
        send(RB, 1'b0, 1'b0);
        chk("R6 second word compared", W'(hit_flag), 1);
        clear_flag();
        pulse_sof();
        send(JUNK, 1'b0, 1'b0);
        send(JUNK, 1'b0, 1'b0);
        send(RA, 1'b0, 1'b0);
        chk("R6 third word ignored", W'(hit_flag), 0);
        win_mode = 2'd3;
        send(RA, 1'b0, 1'b0);
        chk("R6 mode 3 compares all", W'(hit_flag), 1);
        clear_flag();
        win_mode = 2'd0;
    endtask

    task automatic t_hunt();
        cmp_mode = 2'd1; hunt = 1'b1;
        send(JUNK, 1'b0, 1'b0);
        chk("R9 junk dropped", W'(store_vld), 0);
        send(RA, 1'b0, 1'b0);
        chk("R9 hit word stored", W'(store_vld), 1);
        chk("R9 hit word data", store_data, RA);
        send(32'h0000_2222, 1'b0, 1'b0);
        chk("R9 later word stored", W'(store_vld), 1);
        chk("R9 later data", store_data, 32'h0000_2222);
        clear_flag();
        send(JUNK, 1'b0, 1'b0);
        chk("R10 dropping resumes", W'(store_vld), 0);
        send(RB, 1'b0, 1'b0);
        @(negedge clk);
        hunt = 1'b0;
        clear_flag();
        send(32'h0000_3333, 1'b0, 1'b0);
        chk("R10 normal storage", W'(store_vld), 1);
        chk("R10 normal data", store_data, 32'h0000_3333);
    endtask

    task automatic t_off();
        cmp_mode = 2'd0;
        send(RA, 1'b0, 1'b0);
        chk("R12 mode 0 no hit", W'(hit_flag), 0);
        cmp_mode = 2'd3;
        send(RB, 1'b0, 1'b0);
        chk("R12 mode 3 no hit", W'(hit_flag), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_either();
        t_mask();
        t_masked_mode();
        t_first1();
        t_first2();
        t_hunt();
        t_off();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule